// File: doc/BRIEF.md
# SMBus Slave Read-Transfer Controller

This block is the slave end of a two-wire SMBus/I2C link, and it serves transfers in which the master reads. It watches the synchronized clock and data lines for START and STOP. After a START it takes in an address byte, which is seven address bits followed by a direction bit, and compares the address with a programmable value under a programmable mask. It can acknowledge the address in hardware. It can also raise an ACK-request flag and let software pick ACK or NACK. Once a read address is acknowledged, it shifts out bytes that software loads through a write strobe, most significant bit first. After every byte it samples the master's acknowledge bit and raises an interrupt flag. Software clears that flag.

While the interrupt flag is set, the controller holds SCL low, so the master waits for software. Software supplies the next byte before clearing the flag. If it clears the flag without supplying a byte, the controller leaves transmitter mode. An address that is not acknowledged silences the controller until the next START. A four-bit status vector reports the transfer phase.

Top module: `smbs_slave_tx`

## Requirements
- R1: After reset, irq, ack_req, mst_nack, wr_err, scl_oe and sda_oe are 0, and status is 4'b0000.
- R2: status bit 3 is always 0. Bit 2 is transmitter mode. Bit 1 is set by a START and cleared by a STOP. Bit 0 is set by a STOP and cleared by a START. A START while enable is 0 changes no status bit and starts no transfer.
- R3: The address byte arrives MSB first: seven address bits, then the direction bit (1 = read). With hw_ack_en=1 the controller pulls SDA low during the ninth clock only when ((addr ^ own_addr) & addr_mask) == 0. A mask bit of 0 makes that address bit a don't-care.
- R4: With hw_ack_en=1, irq rises at the SCL fall that ends the address ACK bit. ack_req stays 0 and status bit 2 becomes 1.
- R5: With hw_ack_en=0, irq and ack_req rise at the SCL fall that ends the eighth address bit. The controller drives ACK in the ninth bit only if sw_ack is 1 when irq_clr is pulsed. A byte written before that clear is sent right after the ACK, with no further interrupt.
- R6: An address that is not acknowledged, by hardware mismatch or software NACK, leaves SDA released and irq low for all further clocks until the next START. After that START, the address is checked again.
- R7: A byte written through tx_wr is shifted out MSB first. sda_oe changes only while SCL is low.
- R8: After each data byte, mst_nack takes the SDA level of the ninth clock (1 = NACK), and irq rises at the SCL fall that ends that bit. This holds in both ACK modes.
- R9: While irq is 1, SCL is held low (scl_oe=1), even when the master releases it. A pulse on irq_clr releases it.
- R10: Pulsing irq_clr after a transmit interrupt with no tx_wr since the last byte was loaded clears status bit 2 and leaves SDA released.
- R11: A tx_wr while irq is set after a NACK sets wr_err, which stays set until the next START. That byte is never driven.
- R12: A STOP clears status bit 2 and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Accept START conditions (slave events) |
| hw_ack_en | input | 1 | 1 = hardware address ACK, 0 = software decides |
| own_addr | input | ADDR_W | Programmed slave address |
| addr_mask | input | ADDR_W | Compare mask, 1 = bit is compared |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| tx_data | input | DATA_W | Byte to transmit |
| tx_wr | input | 1 | Write strobe for tx_data |
| irq_clr | input | 1 | Clear the interrupt flag |
| sw_ack | input | 1 | Software address response, 1 = ACK, used at irq_clr |
| irq | output | 1 | Interrupt flag |
| ack_req | output | 1 | Software address decision pending |
| mst_nack | output | 1 | Last acknowledge bit from master, 1 = NACK |
| wr_err | output | 1 | Write after NACK detected |
| status | output | 4 | {0, tx mode, START seen, STOP seen} |

## Verification
A change on scl_i or sda_i reaches the outputs on the third rising clock edge: two synchronizer flops, then the state register. The bench therefore keeps every bus level for eight clocks and compares only after that phase has ended. A pulse on irq_clr or tx_wr acts on the next edge. The bench waits two clocks after the pulse before it compares again. A behavioural model updates the expected flags and status after each bus phase or software action, and the outputs are compared with it on every clock of the settled window. Bits driven by the slave are read back from the resolved SDA line in the middle of the SCL high time.

// File: rtl/smbs_pkg.sv
package smbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AWAIT,
    ST_AACK,
    ST_TX,
    ST_TACK,
    ST_TWAIT,
    ST_QUIET
  } smbs_state_e;

  localparam int STATUS_W = 4;

endpackage

// File: rtl/smbs_sync.sv
module smbs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/smbs_bus_events.sv
module smbs_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);

  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  // START/STOP: SDA edge while SCL stays high
  assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;
  assign ev_rise  = ~scl_p & scl_s;
  assign ev_fall  = scl_p & ~scl_s;

endmodule

// File: rtl/smbs_addr_match.sv
module smbs_addr_match #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] addr_mask,
  output logic              hit
);

  logic [ADDR_W-1:0] bit_ok;

  for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
    assign bit_ok[g] = ~addr_mask[g] | (rx_addr[g] ~^ own_addr[g]);
  end

  assign hit = &bit_ok;

endmodule

// File: rtl/smbs_engine.sv
module smbs_engine
  import smbs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              hw_ack_en,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              sda_s,
  input  logic              addr_hit,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_wr,
  input  logic              irq_clr,
  input  logic              sw_ack,
  output logic [ADDR_W-1:0] rx_addr,
  output logic              irq,
  output logic              ack_req,
  output logic              sda_oe,
  output logic              mst_nack,
  output logic              wr_err,
  output logic [STATUS_W-1:0] status
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  smbs_state_e       st;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] dreg;
  logic [CNT_W-1:0]  cnt;
  logic              pend;
  logic              rnw;
  logic              txmode;
  logic              sta_f;
  logic              sto_f;

  assign rx_addr = shreg[ADDR_W:1];
  assign status  = {1'b0, txmode, sta_f, sto_f};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      shreg    <= '0;
      dreg     <= '0;
      cnt      <= '0;
      pend     <= 1'b0;
      rnw      <= 1'b0;
      txmode   <= 1'b0;
      sta_f    <= 1'b0;
      sto_f    <= 1'b0;
      irq      <= 1'b0;
      ack_req  <= 1'b0;
      sda_oe   <= 1'b0;
      mst_nack <= 1'b0;
      wr_err   <= 1'b0;
    end else begin
      if (tx_wr) begin
        dreg <= tx_data;
        pend <= 1'b1;
        if (st == ST_TWAIT && mst_nack) wr_err <= 1'b1;
      end

      if (ev_stop) begin
        st      <= ST_IDLE;
        txmode  <= 1'b0;
        sta_f   <= 1'b0;
        sto_f   <= 1'b1;
        sda_oe  <= 1'b0;
        irq     <= 1'b0;
        ack_req <= 1'b0;
        pend    <= 1'b0;
      end else if (ev_start && enable) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        sta_f    <= 1'b1;
        sto_f    <= 1'b0;
        txmode   <= 1'b0;
        sda_oe   <= 1'b0;
        irq      <= 1'b0;
        ack_req  <= 1'b0;
        pend     <= 1'b0;
        wr_err   <= 1'b0;
        mst_nack <= 1'b0;
      end else if (ev_start) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (ev_rise) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (ev_fall && cnt == BYTE_END) begin
              rnw <= shreg[0];
              cnt <= '0;
              if (hw_ack_en) begin
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                  st     <= ST_AACK;
                end else begin
                  st <= ST_QUIET;
                end
              end else begin
                irq     <= 1'b1;
                ack_req <= 1'b1;
                st      <= ST_AWAIT;
              end
            end
          end
          ST_AWAIT: begin
            if (irq_clr) begin
              irq     <= 1'b0;
              ack_req <= 1'b0;
              if (sw_ack) begin
                sda_oe <= 1'b1;
                st     <= ST_AACK;
              end else begin
                st <= ST_QUIET;
              end
            end
          end
          ST_AACK: begin
            if (ev_fall) begin
              sda_oe   <= 1'b0;
              mst_nack <= 1'b0;
              if (!rnw) begin
                st <= ST_QUIET;
              end else if (hw_ack_en) begin
                txmode <= 1'b1;
                irq    <= 1'b1;
                st     <= ST_TWAIT;
              end else if (pend) begin
                txmode <= 1'b1;
                shreg  <= dreg;
                sda_oe <= ~dreg[DATA_W-1];
                pend   <= 1'b0;
                cnt    <= '0;
                st     <= ST_TX;
              end else begin
                st <= ST_QUIET;
              end
            end
          end
          ST_TX: begin
            if (ev_fall) begin
              if (cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                st     <= ST_TACK;
              end else begin
                sda_oe <= ~shreg[DATA_W-2];
                shreg  <= {shreg[DATA_W-2:0], 1'b0};
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_TACK: begin
            if (ev_rise) mst_nack <= sda_s;
            if (ev_fall) begin
              irq <= 1'b1;
              st  <= ST_TWAIT;
            end
          end
          ST_TWAIT: begin
            if (irq_clr) begin
              irq <= 1'b0;
              if (mst_nack) begin
                st <= ST_QUIET;
              end else if (pend) begin
                shreg  <= dreg;
                sda_oe <= ~dreg[DATA_W-1];
                pend   <= 1'b0;
                cnt    <= '0;
                st     <= ST_TX;
              end else begin
                txmode <= 1'b0;
                st     <= ST_QUIET;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/smbs_slave_tx.sv
module smbs_slave_tx #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              hw_ack_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] addr_mask,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_wr,
  input  logic              irq_clr,
  input  logic              sw_ack,
  output logic              irq,
  output logic              ack_req,
  output logic              mst_nack,
  output logic              wr_err,
  output logic [3:0]        status
);

  logic [1:0]        line_s;
  logic              scl_s, sda_s;
  logic              ev_start, ev_stop, ev_rise, ev_fall;
  logic [ADDR_W-1:0] rx_addr;
  logic              addr_hit;

  smbs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (line_s)
  );

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  smbs_bus_events u_events (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall)
  );

  smbs_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .rx_addr   (rx_addr),
    .own_addr  (own_addr),
    .addr_mask (addr_mask),
    .hit       (addr_hit)
  );

  smbs_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .hw_ack_en (hw_ack_en),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .ev_rise   (ev_rise),
    .ev_fall   (ev_fall),
    .sda_s     (sda_s),
    .addr_hit  (addr_hit),
    .tx_data   (tx_data),
    .tx_wr     (tx_wr),
    .irq_clr   (irq_clr),
    .sw_ack    (sw_ack),
    .rx_addr   (rx_addr),
    .irq       (irq),
    .ack_req   (ack_req),
    .sda_oe    (sda_oe),
    .mst_nack  (mst_nack),
    .wr_err    (wr_err),
    .status    (status)
  );

  // stretch SCL for as long as the interrupt flag is pending
  assign scl_oe = irq;

endmodule

// File: rtl/smbs_slave_tx_chk.sv
module smbs_slave_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       ev_stop,
  input logic       irq,
  input logic       ack_req,
  input logic       sda_oe,
  input logic       mst_nack,
  input logic       wr_err,
  input logic [3:0] status
);

  // R9: the flag, and so the stretch, only starts while SCL is already low
  assert_irq_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !scl_s);

  // R7: SDA drive does not move while SCL stays high
  assert_sda_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R5: an ACK request always comes with a pending interrupt
  assert_ackreq_irq_R5: assert property (@(posedge clk) disable iff (rst)
    ack_req |-> irq);

  // R11: the error flag only rises during a post-NACK interrupt
  assert_err_nack_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_err) |-> (irq && mst_nack));

  // R2: top bit zero, START/STOP bits never both set
  assert_status_R2: assert property (@(posedge clk) disable iff (rst)
    (!status[3] && $onehot0(status[1:0])));

  // R12: after a STOP, transmitter mode is off
  assert_stop_exit_R12: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> (!status[2] && !sda_oe));

endmodule

bind smbs_slave_tx smbs_slave_tx_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_s    (scl_s),
  .ev_stop  (ev_stop),
  .irq      (irq),
  .ack_req  (ack_req),
  .sda_oe   (sda_oe),
  .mst_nack (mst_nack),
  .wr_err   (wr_err),
  .status   (status)
);

// File: tb/test_smbs_slave_tx.sv
module test_smbs_slave_tx;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       enable = 1'b1, hw_ack_en = 1'b1;
  logic [6:0] own_addr = 7'h2A, addr_mask = 7'h7F;
  logic       scl_drv = 1'b1, sda_drv = 1'b1;
  logic       scl_oe, sda_oe;
  logic [7:0] tx_data = '0;
  logic       tx_wr = 1'b0, irq_clr = 1'b0, sw_ack = 1'b0;
  logic       irq, ack_req, mst_nack, wr_err;
  logic [3:0] status;
  logic       scl_ln, sda_ln;

  assign scl_ln = scl_drv & ~scl_oe;
  assign sda_ln = sda_drv & ~sda_oe;

  smbs_slave_tx i_smbs_slave_tx (
    .clk(clk), .rst(rst), .enable(enable), .hw_ack_en(hw_ack_en),
    .own_addr(own_addr), .addr_mask(addr_mask),
    .scl_i(scl_ln), .sda_i(sda_ln), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .tx_data(tx_data), .tx_wr(tx_wr), .irq_clr(irq_clr), .sw_ack(sw_ack),
    .irq(irq), .ack_req(ack_req), .mst_nack(mst_nack), .wr_err(wr_err),
    .status(status)
  );

  int    n_chk = 0, n_err = 0;
  bit    done = 0;
  bit    cmp_en = 0;
  string tag = "R1";

  // behavioural model state
  logic       e_irq = 0, e_ackreq = 0, e_nack = 0, e_err = 0;
  logic [3:0] e_status = 4'b0000;

  task automatic check(string t, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h at %0t", t, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done)
      check(tag, {irq, ack_req, e_nack ? mst_nack : mst_nack, wr_err, status},
                 {e_irq, e_ackreq, e_nack, e_err, e_status});
  end

  task automatic hold(string t, int n);
    tag = t;
    cmp_en = 1;
    repeat (n) @(negedge clk);
    cmp_en = 0;
  endtask

  task automatic ph();
    repeat (8) @(negedge clk);
  endtask

  task automatic scl_up();
    int n = 0;
    scl_drv = 1'b1;
    while (scl_ln !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) check("R9 SCL release", 0, 1);
    ph();
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; ph();
    scl_up();
    sda_drv = 1'b0; ph();
    scl_drv = 1'b0; ph();
  endtask

  task automatic bus_stop();
    scl_drv = 1'b0; sda_drv = 1'b0; ph();
    scl_up();
    sda_drv = 1'b1; ph();
  endtask

  task automatic wbit(logic b);
    sda_drv = b; ph();
    scl_up();
    scl_drv = 1'b0; ph();
  endtask

  task automatic rbit(output logic r);
    sda_drv = 1'b1; ph();
    scl_up();
    r = sda_ln;
    scl_drv = 1'b0; ph();
  endtask

  task automatic wbyte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
  endtask

  task automatic rbyte(output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      rbit(r);
      b[i] = r;
    end
  endtask

  task automatic sw_write(logic [7:0] d);
    tx_data = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sw_clear();
    irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic       a;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 scl_oe/sda_oe", {scl_oe, sda_oe}, 0);
    hold("R1", 4);

    // ---- hardware ACK, full read with ACK then NACK
    bus_start();
    e_status = 4'b0010;
    hold("R2 START", 3);
    wbyte(8'h55);
    rbit(a);
    check("R3 addr ACK", a, 0);
    e_irq = 1; e_status = 4'b0110;
    hold("R4 irq after ACK", 3);
    scl_drv = 1'b1;
    repeat (10) @(negedge clk);
    check("R9 SCL held low", scl_ln, 0);
    scl_drv = 1'b0;
    sw_write(8'hA5);
    sw_clear();
    e_irq = 0;
    hold("R9 clear", 2);
    rbyte(d);
    check("R7 byte A5", d, 8'hA5);
    wbit(1'b0);
    e_irq = 1; e_nack = 0;
    hold("R8 ACK byte", 3);
    sw_write(8'h3C);
    sw_clear();
    e_irq = 0;
    rbyte(d);
    check("R7 byte 3C", d, 8'h3C);
    wbit(1'b1);
    e_irq = 1; e_nack = 1;
    hold("R8 NACK byte", 3);
    sw_write(8'h00);
    e_err = 1;
    hold("R11 write after NACK", 3);
    sw_clear();
    e_irq = 0;
    hold("R11 after clear", 3);
    rbit(a);
    check("R11 byte not driven", a, 1);
    bus_stop();
    e_status = 4'b0001;
    hold("R12 STOP", 3);
    check("R12 sda released", sda_oe, 0);

    // ---- mismatch, inhibit, then repeated START re-arms
    bus_start();
    e_status = 4'b0010; e_err = 0; e_nack = 0;
    hold("R11 cleared by START", 3);
    wbyte(8'h27);
    rbit(a);
    check("R6 mismatch NACK", a, 1);
    hold("R6 no irq", 3);
    rbyte(d);
    check("R6 silent", d, 8'hFF);
    rbit(a);
    hold("R6 still no irq", 3);
    bus_start();
    wbyte(8'h55);
    rbit(a);
    check("R6 re-armed ACK", a, 0);
    e_irq = 1; e_status = 4'b0110;
    hold("R4", 3);
    sw_clear();
    e_irq = 0; e_status = 4'b0010;
    hold("R10 fallback", 3);
    rbit(a);
    check("R10 SDA released", a, 1);
    bus_stop();
    e_status = 4'b0001;
    hold("R12", 2);

    // ---- mask handling
    addr_mask = 7'h70;
    bus_start();
    e_status = 4'b0010;
    wbyte(8'h5F);
    rbit(a);
    check("R3 masked match", a, 0);
    e_irq = 1; e_status = 4'b0110;
    hold("R3 mask irq", 2);
    sw_clear();
    e_irq = 0; e_status = 4'b0010;
    bus_stop();
    e_status = 4'b0001;
    bus_start();
    e_status = 4'b0010;
    wbyte(8'h75);
    rbit(a);
    check("R3 masked mismatch", a, 1);
    hold("R3 no irq", 2);
    bus_stop();
    addr_mask = 7'h00;
    bus_start();
    wbyte(8'hFF);
    rbit(a);
    check("R3 zero mask", a, 0);
    e_irq = 1; e_status = 4'b0110;
    hold("R3", 2);
    sw_clear();
    e_irq = 0; e_status = 4'b0010;
    bus_stop();
    e_status = 4'b0001;
    addr_mask = 7'h7F;

    // ---- software ACK mode
    hw_ack_en = 1'b0;
    bus_start();
    e_status = 4'b0010;
    wbyte(8'h55);
    e_irq = 1; e_ackreq = 1;
    hold("R5 request", 3);
    sw_ack = 1'b1;
    sw_write(8'h81);
    sw_clear();
    e_irq = 0; e_ackreq = 0;
    hold("R5 cleared", 2);
    rbit(a);
    check("R5 sw ACK", a, 0);
    e_status = 4'b0110;
    hold("R5 straight to TX", 3);
    rbyte(d);
    check("R7 byte 81", d, 8'h81);
    wbit(1'b0);
    e_irq = 1;
    hold("R8 sw mode", 3);
    sw_clear();
    e_irq = 0; e_status = 4'b0010;
    hold("R10", 3);
    bus_stop();
    e_status = 4'b0001;

    // ---- software NACK
    bus_start();
    e_status = 4'b0010;
    wbyte(8'h55);
    e_irq = 1; e_ackreq = 1;
    hold("R5", 2);
    sw_ack = 1'b0;
    sw_clear();
    e_irq = 0; e_ackreq = 0;
    rbit(a);
    check("R6 sw NACK", a, 1);
    rbyte(d);
    check("R6 silent after NACK", d, 8'hFF);
    hold("R6", 3);
    bus_stop();
    e_status = 4'b0001;
    hw_ack_en = 1'b1;

    // ---- disabled: START ignored
    enable = 1'b0;
    bus_start();
    hold("R2 disabled START", 3);
    wbyte(8'h55);
    rbit(a);
    check("R2 disabled no ACK", a, 1);
    hold("R2 disabled", 3);
    bus_stop();
    hold("R2", 2);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule